// File: doc/BRIEF.md
# H4 Host-Controller Receive Deframer

This block sits behind a UART receiver and turns its byte stream into whole host-controller packets. Every byte that arrives with its valid strobe is written into a local packet buffer. A three-phase controller follows the framing. The first phase takes the packet type and the byte after it. The second phase gathers the rest of the header, whose size depends on the type. The third phase gathers the payload, whose size is decoded from the header. When the last byte of a packet has been written, the block pulses a done strobe and presents the packet's type code and total byte count. The bytes stay in the buffer and can be read through a separate read port.

Malformed input is rejected without stopping the stream. A type byte with no known meaning is dropped and raises a one-cycle error strobe. A header that announces a packet larger than the buffer raises a different error strobe and throws the partial packet away. In both cases the next byte is treated as a fresh type byte. One variant of command packet, the vendor opcode 0xFC00, carries one more payload byte than its length field states whenever that field is odd.

Top module: `hci_rx_deframer`

## Requirements
- R1: After reset, `pktDone`, `errUnknown` and `errOversize` are low, and the first accepted byte is taken as a packet type.
- R2: The accepted type codes are 1, 2, 3, 4, 6 and 7. Any other first byte gives a one-cycle `errUnknown` pulse in the cycle after it is accepted. That byte is not counted, and the following byte is again taken as a type.
- R3: A command packet (type 1) carries a 16-bit little-endian opcode in bytes 1–2 and a length in byte 3. Its total length is 4 plus that length.
- R4: When the command opcode equals 0xFC00 (byte 1 = 0x00, byte 2 = 0xFC), the payload length is byte 3 rounded up to the next even value.
- R5: An event packet (type 4) has a length in byte 2. Its total length is 3 plus that length.
- R6: An ACL data packet (type 2) carries a 16-bit little-endian payload length in bytes 3–4. Its total length is 5 plus that length.
- R7: A SCO data packet (type 3) has a length in byte 3. Its total length is 4 plus that length.
- R8: A negotiation packet (type 6) is exactly byte 1 plus 2 bytes long and has no payload. This includes a 2-byte packet when byte 1 is 0.
- R9: A keep-alive packet (type 7) is always 4 bytes long and has no payload.
- R10: A packet of exactly `BUF_DEPTH` bytes is delivered normally. If the computed total exceeds `BUF_DEPTH`, a one-cycle `errOversize` pulse follows the last header byte, the packet is discarded, and the next byte is a type byte.
- R11: `pktDone` pulses for one cycle, in the cycle after the final byte is accepted, and at most one of the three strobes is high in any cycle. While it is high, `pktType` and `pktLen` hold the packet's type and byte count. Byte i of the packet sits at buffer address i, and `rdData` shows the byte at `rdAddr` one cycle after the address is applied.
- R12: The type byte of the next packet may be accepted in the very cycle after the final byte of the previous packet.
- R13: While `rxValid` is low, `rxByte` is ignored and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | `rxByte` holds a received byte this cycle |
| rxByte | input | 8 | Received byte |
| rdAddr | input | ADDR_W | Buffer read address |
| rdData | output | 8 | Buffer byte at the previous cycle's `rdAddr` |
| pktDone | output | 1 | A complete packet is in the buffer |
| pktType | output | 8 | Type code of the completed packet |
| pktLen | output | CNT_W | Total bytes of the completed packet, type byte included |
| errUnknown | output | 1 | An unrecognised type byte was dropped |
| errOversize | output | 1 | A packet longer than the buffer was dropped |

## Verification
The hardest situation to reach from the ports is the length boundary at the buffer size. To test it, ACL headers are sent whose 16-bit length field makes the total exactly `BUF_DEPTH`, and one byte more. The exact-fit packet is then streamed with no gaps. The other hard situations are the edge cases where the header completes the packet: a negotiation packet with length 0, an event with length 0, and a vendor command with length 0. These are fed back to back with other packets, so the next packet's type byte arrives in the cycle right after a completion. Junk is placed on the byte input during the gaps where the valid strobe is low.

// File: rtl/hci_rx_pkg.sv
package hci_rx_pkg;

  localparam int LEN_FIELD_W = 16;

  localparam logic [7:0] TY_CMD   = 8'd1;
  localparam logic [7:0] TY_ACL   = 8'd2;
  localparam logic [7:0] TY_SCO   = 8'd3;
  localparam logic [7:0] TY_EVT   = 8'd4;
  localparam logic [7:0] TY_NEG   = 8'd6;
  localparam logic [7:0] TY_ALIVE = 8'd7;

  localparam logic [15:0] VENDOR_OPC = 16'hFC00;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_HEAD,
    PH_BODY
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wr;
    logic capType;
    logic capHdr;
    logic capTot;
    logic finish;
    logic dropUnk;
    logic dropOver;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cntZero;
    logic typeKnown;
    logic hitNeed;
    logic leadShort;
    logic payZero;
    logic oversize;
  } status_t;

  function automatic logic isKnownType(input logic [7:0] t);
    return (t == TY_CMD) || (t == TY_ACL) || (t == TY_SCO) ||
           (t == TY_EVT) || (t == TY_NEG) || (t == TY_ALIVE);
  endfunction

  // header size including the type byte, for types with a fixed header
  function automatic logic [3:0] fixedHdrTotal(input logic [7:0] t);
    case (t)
      TY_CMD:   return 4'd4;
      TY_EVT:   return 4'd3;
      TY_ACL:   return 4'd5;
      TY_SCO:   return 4'd4;
      TY_ALIVE: return 4'd4;
      default:  return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/hci_rx_ctrl.sv
module hci_rx_ctrl
  import hci_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxValid,
  input  status_t st,
  output strobe_t stb
);

  phase_e phase, phaseNext;

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    if (rxValid) begin
      unique case (phase)
        PH_LEAD: begin
          if (st.cntZero) begin
            if (st.typeKnown) begin
              stb.wr      = 1'b1;
              stb.capType = 1'b1;
            end else begin
              stb.dropUnk = 1'b1;
            end
          end else begin
            stb.wr = 1'b1;
            if (st.leadShort) begin
              stb.finish = 1'b1;
            end else begin
              stb.capHdr = 1'b1;
              phaseNext  = PH_HEAD;
            end
          end
        end
        PH_HEAD: begin
          stb.wr = 1'b1;
          if (st.hitNeed) begin
            if (st.oversize) begin
              stb.dropOver = 1'b1;
              phaseNext    = PH_LEAD;
            end else if (st.payZero) begin
              stb.finish = 1'b1;
              phaseNext  = PH_LEAD;
            end else begin
              stb.capTot = 1'b1;
              phaseNext  = PH_BODY;
            end
          end
        end
        PH_BODY: begin
          stb.wr = 1'b1;
          if (st.hitNeed) begin
            stb.finish = 1'b1;
            phaseNext  = PH_LEAD;
          end
        end
        default: phaseNext = PH_LEAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_LEAD;
    else       phase <= phaseNext;
  end

  AST_FINISH_TO_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (phase == PH_LEAD)); // R12

  AST_DROP_TO_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropOver |=> (phase == PH_LEAD)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(phase)); // R13

endmodule

// File: rtl/hci_rx_dp.sv
module hci_rx_dp
  import hci_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 4096,
  localparam int ADDR_W = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1),
  localparam int TOT_W  = LEN_FIELD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  strobe_t           stb,
  output status_t           st,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              pktDone,
  output logic [7:0]        pktType,
  output logic [CNT_W-1:0]  pktLen,
  output logic              errUnknown,
  output logic              errOversize
);

  logic [7:0]       mem [BUF_DEPTH];
  logic [CNT_W-1:0] count, nextCount;
  logic [TOT_W-1:0] need;
  logic [7:0]       typeReg, byte1, byte2, byte3;
  logic [TOT_W-1:0] hdrTotal, payLen, totLen;
  logic [8:0]       evenLen;

  assign nextCount = count + CNT_W'(1);
  assign evenLen   = ({1'b0, rxByte} + 9'd1) & 9'h1FE;

  always_comb begin
    if (typeReg == TY_NEG) hdrTotal = TOT_W'(rxByte) + TOT_W'(2);
    else                   hdrTotal = TOT_W'(fixedHdrTotal(typeReg));
  end

  // payload size, decoded as the last header byte arrives
  always_comb begin
    case (typeReg)
      TY_CMD:  payLen = ({byte2, byte1} == VENDOR_OPC) ? TOT_W'(evenLen)
                                                       : TOT_W'(rxByte);
      TY_EVT:  payLen = TOT_W'(rxByte);
      TY_ACL:  payLen = TOT_W'({rxByte, byte3});
      TY_SCO:  payLen = TOT_W'(rxByte);
      default: payLen = '0;
    endcase
  end

  assign totLen = need + payLen;

  always_comb begin
    st.cntZero   = (count == '0);
    st.typeKnown = isKnownType(rxByte);
    st.hitNeed   = (TOT_W'(nextCount) == need);
    st.leadShort = (hdrTotal == TOT_W'(2));
    st.payZero   = (payLen == '0);
    st.oversize  = (totLen > TOT_W'(BUF_DEPTH));
  end

  always_ff @(posedge clk) begin
    if (stb.wr) mem[count[ADDR_W-1:0]] <= rxByte;
    rdData <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      need    <= TOT_W'(2);
      typeReg <= '0;
      byte1   <= '0;
      byte2   <= '0;
      byte3   <= '0;
    end else begin
      if (stb.finish || stb.dropOver) count <= '0;
      else if (stb.wr)                count <= nextCount;
      if (stb.capType) typeReg <= rxByte;
      if (stb.wr && count == CNT_W'(1)) byte1 <= rxByte;
      if (stb.wr && count == CNT_W'(2)) byte2 <= rxByte;
      if (stb.wr && count == CNT_W'(3)) byte3 <= rxByte;
      if (stb.capHdr)                       need <= hdrTotal;
      else if (stb.capTot)                  need <= totLen;
      else if (stb.finish || stb.dropOver)  need <= TOT_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktDone     <= 1'b0;
      pktType     <= '0;
      pktLen      <= '0;
      errUnknown  <= 1'b0;
      errOversize <= 1'b0;
    end else begin
      pktDone     <= stb.finish;
      errUnknown  <= stb.dropUnk;
      errOversize <= stb.dropOver;
      if (stb.finish) begin
        pktType <= typeReg;
        pktLen  <= nextCount;
      end
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktDone, errUnknown, errOversize})); // R11

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> $past(stb.wr)); // R11

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (pktLen >= CNT_W'(2) && pktLen <= CNT_W'(BUF_DEPTH))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(BUF_DEPTH)); // R10

  AST_UNK_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    errUnknown |-> ($past(count) == '0 && count == '0)); // R2

  AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (count == '0)); // R12

endmodule

// File: rtl/hci_rx_deframer.sv
module hci_rx_deframer
  import hci_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 4096,
  localparam int ADDR_W = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              pktDone,
  output logic [7:0]        pktType,
  output logic [CNT_W-1:0]  pktLen,
  output logic              errUnknown,
  output logic              errOversize
);

  strobe_t stb;
  status_t st;

  hci_rx_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .st      (st),
    .stb     (stb)
  );

  hci_rx_dp #(.BUF_DEPTH(BUF_DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxByte      (rxByte),
    .stb         (stb),
    .st          (st),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .pktDone     (pktDone),
    .pktType     (pktType),
    .pktLen      (pktLen),
    .errUnknown  (errUnknown),
    .errOversize (errOversize)
  );

endmodule

// File: tb/hci_rx_deframer_tb_top.sv
module hci_rx_deframer_tb_top;

  localparam int DEPTH  = 4096;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rxValid = 1'b0;
  logic [7:0]        rxByte = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              pktDone, errUnknown, errOversize;
  logic [7:0]        pktType;
  logic [CNT_W-1:0]  pktLen;

  always #10 clk = ~clk;

  hci_rx_deframer #(.BUF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rdAddr(rdAddr), .rdData(rdData), .pktDone(pktDone),
    .pktType(pktType), .pktLen(pktLen),
    .errUnknown(errUnknown), .errOversize(errOversize)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // kind: 0 packet done, 1 unknown type, 2 oversize
  typedef struct {
    int    kind;
    int    ty;
    int    len;
    string req;
  } exp_t;

  exp_t       expQ[$];
  logic [7:0] txq[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expectItem(input int kind, input int ty, input int len, input string req);
    exp_t e;
    e.kind = kind; e.ty = ty; e.len = len; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic addPay(input int n, input int seed);
    for (int i = 0; i < n; i++) txq.push_back(8'(seed + i));
  endtask

  task automatic sendTx(input bit gapless);
    for (int i = 0; i < txq.size(); i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxByte  = txq[i];
      if (!gapless) begin
        @(negedge clk);
        rxValid = 1'b0;
        rxByte  = 8'h05;  // junk, must be ignored (R13)
      end
    end
    if (gapless) begin
      @(negedge clk);
      rxValid = 1'b0;
      rxByte  = 8'hFF;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard consumer
  always @(negedge clk) begin
    exp_t e;
    int   kind;
    if (rstN && (pktDone || errUnknown || errOversize)) begin
      kind = pktDone ? 0 : (errUnknown ? 1 : 2);
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected strobe", kind, -1);
      end else begin
        e = expQ.pop_front();
        check(kind == e.kind, {e.req, " strobe kind"}, kind, e.kind);
        if (kind == 0 && e.kind == 0) begin
          check(int'(pktType) == e.ty, {e.req, " type"}, int'(pktType), e.ty);
          check(int'(pktLen) == e.len, {e.req, " length"}, int'(pktLen), e.len);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int strobes;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!pktDone && !errUnknown && !errOversize, "R1 strobes in reset",
          int'({pktDone, errUnknown, errOversize}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pktDone && !errUnknown && !errOversize, "R1 strobes after reset",
          int'({pktDone, errUnknown, errOversize}), 0);

    // R3: plain command, opcode 0x0C03, length 5
    txq = {8'h01, 8'h03, 8'h0C, 8'h05}; addPay(5, 8'h40);
    expectItem(0, 1, 9, "R1 R3"); sendTx(1'b0);

    // R11: buffer readback, one cycle latency
    for (int i = 0; i < txq.size(); i++) begin
      @(negedge clk); rdAddr = ADDR_W'(i);
      @(negedge clk);
      check(rdData == txq[i], "R11 buffer byte", int'(rdData), int'(txq[i]));
    end

    // R4: vendor opcode, odd / even / zero length
    txq = {8'h01, 8'h00, 8'hFC, 8'h05}; addPay(6, 8'h10);
    expectItem(0, 1, 10, "R4 odd"); sendTx(1'b0);
    txq = {8'h01, 8'h00, 8'hFC, 8'h04}; addPay(4, 8'h20);
    expectItem(0, 1, 8, "R4 even"); sendTx(1'b1);
    txq = {8'h01, 8'h00, 8'hFC, 8'h00};
    expectItem(0, 1, 4, "R4 zero"); sendTx(1'b0);
    // R3: odd length on a non-vendor opcode is not rounded
    txq = {8'h01, 8'h00, 8'hFD, 8'h03}; addPay(3, 8'h30);
    expectItem(0, 1, 7, "R3 no round"); sendTx(1'b1);

    // R5: events
    txq = {8'h04, 8'h0E, 8'h03}; addPay(3, 8'h50);
    expectItem(0, 4, 6, "R5"); sendTx(1'b0);
    txq = {8'h04, 8'h0F, 8'h00};
    expectItem(0, 4, 3, "R5 empty"); sendTx(1'b0);

    // R6: ACL, both length bytes
    txq = {8'h02, 8'h01, 8'h00, 8'h03, 8'h00}; addPay(3, 8'h60);
    expectItem(0, 2, 8, "R6"); sendTx(1'b0);
    txq = {8'h02, 8'h01, 8'h20, 8'h02, 8'h01}; addPay(258, 8'h00);
    expectItem(0, 2, 263, "R6 high byte"); sendTx(1'b1);

    // R7: SCO
    txq = {8'h03, 8'h01, 8'h00, 8'h02}; addPay(2, 8'h70);
    expectItem(0, 3, 6, "R7"); sendTx(1'b0);

    // R8: negotiation
    txq = {8'h06, 8'h0A}; addPay(10, 8'h00);
    expectItem(0, 6, 12, "R8"); sendTx(1'b0);
    txq = {8'h06, 8'h00};
    expectItem(0, 6, 2, "R8 short"); sendTx(1'b0);

    // R9: keep-alive
    txq = {8'h07, 8'h01, 8'h55, 8'h00};
    expectItem(0, 7, 4, "R9"); sendTx(1'b0);

    // R2: unknown types, then a good packet
    txq = {8'h05, 8'h00, 8'hFF, 8'h08, 8'h07, 8'h01, 8'h55, 8'h00};
    expectItem(1, 0, 0, "R2 type5");
    expectItem(1, 0, 0, "R2 type0");
    expectItem(1, 0, 0, "R2 typeFF");
    expectItem(1, 0, 0, "R2 type8");
    expectItem(0, 7, 4, "R2 recover"); sendTx(1'b1);

    // R10: oversize by one, then recovery
    txq = {8'h02, 8'h00, 8'h00, 8'hFC, 8'h0F, 8'h07, 8'h01, 8'h55, 8'h00};
    expectItem(2, 0, 0, "R10 oversize");
    expectItem(0, 7, 4, "R10 recover"); sendTx(1'b0);
    // R10: exact fit
    txq = {8'h02, 8'h00, 8'h00, 8'hFB, 8'h0F}; addPay(4091, 8'h11);
    expectItem(0, 2, DEPTH, "R10 exact fit"); sendTx(1'b1);
    @(negedge clk); rdAddr = ADDR_W'(DEPTH - 1);
    @(negedge clk);
    check(rdData == txq[DEPTH-1], "R10 last buffer byte", int'(rdData), int'(txq[DEPTH-1]));

    // R12: back-to-back packets, header-terminated ones included
    txq = {8'h04, 8'h0E, 8'h01, 8'hAA, 8'h06, 8'h00, 8'h01, 8'h00, 8'hFC, 8'h00,
           8'h07, 8'h01, 8'h55, 8'h00};
    expectItem(0, 4, 4, "R12 first");
    expectItem(0, 6, 2, "R12 second");
    expectItem(0, 1, 4, "R12 third");
    expectItem(0, 7, 4, "R12 fourth"); sendTx(1'b1);

    // R13: idle with junk on the byte input
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rxByte = 8'(i * 37 + 1);
      if (pktDone || errUnknown || errOversize) strobes++;
    end
    check(strobes == 0, "R13 idle strobes", strobes, 0);
    txq = {8'h07, 8'h01, 8'h55, 8'h00};
    expectItem(0, 7, 4, "R13 after idle"); sendTx(1'b0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R11 missing strobes", expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule